// File: doc/BRIEF.md
# VBI Per-Line Insertion Mask Generator

This block follows the field and line position of a video raster during vertical blanking. For each line it sets three flags. The first says whether the black-level pedestal is applied, which matters when the NTSC standard is selected. The second says whether teletext may be inserted, which matters when PAL is selected. The third says whether the line's blanking-interval content is to be blanked rather than passed through. Every line in a window of sixteen lines can be switched on its own by a 16-bit mask. Odd fields and even fields have separate masks, and NTSC and PAL have separate mask sets.

Software loads the masks and a small control byte through a byte-wide write port. Writes land in a shadow copy, and the shadow copy is committed at the next field start, so the masks never change in the middle of a field. The timing logic supplies a field-start strobe, a line-start strobe and the field parity. The flags are registered and change on the clock edge after a strobe.

Top module: `vbi_line_mask`

## Requirements
- R1: During and after reset, ped_en, ttx_win and vbi_blank are 0. All mask bytes and control bits are cleared, and the line count is 0, which lies outside every mapped range.
- R2: field_start sets the line count to 1. line_start without field_start adds one to the line count. When both strobes are high together, field_start wins. The count saturates at 2^LINE_W-1 and does not wrap.
- R3: When std_pal is 0 (NTSC), mask bit k covers line 10+k for k from 0 to 15. A bit of 1 gives ped_en=0 on that line, and a bit of 0 gives ped_en=1.
- R4: In NTSC, lines outside 10..25 have ped_en=1, and ttx_win is always 0.
- R5: When std_pal is 1 (PAL), mask bit k covers line 7+k for k from 0 to 15. ttx_win=1 only when that bit is 1 and the committed teletext-enable bit is set. ped_en is always 0 in PAL.
- R6: In PAL, lines outside 7..22 have ttx_win=0.
- R7: When the committed teletext-enable bit (control bit 0) is 0, ttx_win stays 0 whatever the PAL mask holds.
- R8: vbi_blank=1 exactly on lines from 1 to the last mapped line of the current standard (25 in NTSC, 22 in PAL), and only while the committed pass-through bit (control bit 1) is 0.
- R9: Write addresses are fixed. Addresses 0 to 3 hold the NTSC masks in the order odd low byte, odd high byte, even low byte, even high byte. Addresses 4 to 7 hold the PAL masks in the same order. Address 8 is the control byte. Writes to any other address are ignored. The low byte carries mask bits 7:0.
- R10: A write changes only the shadow copy. The shadow copy becomes active at the next field_start. A write made in the same cycle as field_start becomes active only at the following field_start.
- R11: The flags are registered. They take a new value only on the clock edge after a cycle with line_start or field_start, and they hold at all other times, including when std_pal changes.
- R12: field_odd is sampled at field_start. A value of 1 selects the odd-field mask for the whole field, and a value of 0 selects the even-field mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| std_pal | input | 1 | Standard select: 0 NTSC, 1 PAL |
| field_odd | input | 1 | Field parity, sampled at field start |
| line_start | input | 1 | One-cycle pulse at each new line |
| field_start | input | 1 | One-cycle pulse at the first line of a field |
| ped_en | output | 1 | Pedestal applied on the current line |
| ttx_win | output | 1 | Teletext insertion allowed on the current line |
| vbi_blank | output | 1 | Blanking-interval content blanked on the current line |

## Verification
The hardest behaviour to reach from the ports is the commit timing. A mask write must stay invisible for the rest of the current field. This holds even when the write lands in the same cycle as a field start, and even when line_start and field_start coincide. The stimulus rewrites masks in the middle of a field and on the exact field-start cycle, and it alternates parity so that both the odd and the even mask sets are used. It also runs more than a thousand lines without a field start to show that the count saturates instead of wrapping back into the blanking window. A behavioural model keeps its own shadow and active byte arrays and is compared with all three flags on every clock.

// File: rtl/vbi_mask_pkg.sv
package vbi_mask_pkg;

    localparam int MASK_BITS  = 16;
    localparam int NTSC_FIRST = 10;
    localparam int PAL_FIRST  = 7;

    localparam int ADR_NTSC_BASE = 0;
    localparam int ADR_PAL_BASE  = 4;
    localparam int ADR_CTRL      = 8;

    typedef enum logic {STD_NTSC = 1'b0, STD_PAL = 1'b1} std_e;

    typedef struct packed {
        logic [MASK_BITS-1:0] odd;
        logic [MASK_BITS-1:0] even;
    } mask_pair_t;

    typedef struct packed {
        mask_pair_t ntsc;
        mask_pair_t pal;
        logic       ttx_en;
        logic       vbi_pass;
    } cfg_t;

    typedef struct packed {
        logic ped_en;
        logic ttx_win;
        logic vbi_blank;
    } line_flags_t;

    function automatic line_flags_t decode_flags(input int line, input logic odd,
                                                 input std_e std, input cfg_t cfg);
        line_flags_t          f;
        mask_pair_t           mp;
        logic [MASK_BITS-1:0] m;
        int                   first;
        int                   last;
        logic                 bit_set;
        mp      = (std == STD_PAL) ? cfg.pal : cfg.ntsc;
        m       = odd ? mp.odd : mp.even;
        first   = (std == STD_PAL) ? PAL_FIRST : NTSC_FIRST;
        last    = first + MASK_BITS - 1;
        bit_set = 1'b0;
        if (line >= first && line <= last)
            bit_set = m[4'(line - first)];
        f.ped_en    = (std == STD_NTSC) && !bit_set;
        f.ttx_win   = (std == STD_PAL) && cfg.ttx_en && bit_set;
        f.vbi_blank = !cfg.vbi_pass && (line >= 1) && (line <= last);
        return f;
    endfunction

endpackage

// File: rtl/vbi_reg_bank.sv
module vbi_reg_bank
    import vbi_mask_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              commit,
    output cfg_t              cfg_nxt
);
    cfg_t shadow_q;
    cfg_t active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (wr_en) begin
            case (int'(wr_addr))
                ADR_NTSC_BASE + 0: shadow_q.ntsc.odd[7:0]   <= wr_data;
                ADR_NTSC_BASE + 1: shadow_q.ntsc.odd[15:8]  <= wr_data;
                ADR_NTSC_BASE + 2: shadow_q.ntsc.even[7:0]  <= wr_data;
                ADR_NTSC_BASE + 3: shadow_q.ntsc.even[15:8] <= wr_data;
                ADR_PAL_BASE + 0:  shadow_q.pal.odd[7:0]    <= wr_data;
                ADR_PAL_BASE + 1:  shadow_q.pal.odd[15:8]   <= wr_data;
                ADR_PAL_BASE + 2:  shadow_q.pal.even[7:0]   <= wr_data;
                ADR_PAL_BASE + 3:  shadow_q.pal.even[15:8]  <= wr_data;
                ADR_CTRL: begin
                    shadow_q.ttx_en   <= wr_data[0];
                    shadow_q.vbi_pass <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= '0;
        else if (commit)
            active_q <= shadow_q;
    end

    assign cfg_nxt = commit ? shadow_q : active_q;

    a_r10_no_midfield: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) |-> $stable(active_q));

    a_r10_commit_shadow: assert property (@(posedge clk) disable iff (rst)
        commit |=> active_q == $past(shadow_q));
endmodule

// File: rtl/vbi_line_tracker.sv
module vbi_line_tracker #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              field_start,
    input  logic              field_odd,
    output logic [LINE_W-1:0] line_nxt,
    output logic              odd_nxt
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic [LINE_W-1:0] line_q;
    logic              odd_q;

    always_comb begin
        line_nxt = line_q;
        odd_nxt  = odd_q;
        if (field_start) begin
            line_nxt = LINE_W'(1);
            odd_nxt  = field_odd;
        end else if (line_start && line_q != LINE_MAX) begin
            line_nxt = line_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            odd_q  <= 1'b0;
        end else begin
            line_q <= line_nxt;
            odd_q  <= odd_nxt;
        end
    end

    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        field_start |=> line_q == LINE_W'(1));

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (line_start && !field_start && line_q != LINE_MAX) |=> line_q == $past(line_q) + 1'b1);

    a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
        (!field_start && line_q == LINE_MAX) |=> line_q == LINE_MAX);

    a_r12_parity_hold: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> $stable(odd_q));
endmodule

// File: rtl/vbi_line_mask.sv
module vbi_line_mask
    import vbi_mask_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              std_pal,
    input  logic              field_odd,
    input  logic              line_start,
    input  logic              field_start,
    output logic              ped_en,
    output logic              ttx_win,
    output logic              vbi_blank
);
    cfg_t              cfg_nxt;
    logic [LINE_W-1:0] line_nxt;
    logic              odd_nxt;
    line_flags_t       flags_q;
    logic              strobe;

    assign strobe = line_start | field_start;

    vbi_reg_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (field_start),
        .cfg_nxt (cfg_nxt)
    );

    vbi_line_tracker #(.LINE_W(LINE_W)) u_track (
        .clk         (clk),
        .rst         (rst),
        .line_start  (line_start),
        .field_start (field_start),
        .field_odd   (field_odd),
        .line_nxt    (line_nxt),
        .odd_nxt     (odd_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (strobe)
            flags_q <= decode_flags(int'(line_nxt), odd_nxt, std_e'(std_pal), cfg_nxt);
    end

    assign ped_en    = flags_q.ped_en;
    assign ttx_win   = flags_q.ttx_win;
    assign vbi_blank = flags_q.vbi_blank;

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(strobe) && !$past(rst)) |-> ($stable(ped_en) && $stable(ttx_win) && $stable(vbi_blank)));

    a_r5_ttx_pal_only: assert property (@(posedge clk) disable iff (rst)
        ($past(strobe) && ttx_win) |-> $past(std_pal));

    a_r3_ped_ntsc_only: assert property (@(posedge clk) disable iff (rst)
        ($past(strobe) && ped_en) |-> !$past(std_pal));

    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ped_en, ttx_win}));
endmodule

// File: tb/sim_vbi_line_mask.sv
module sim_vbi_line_mask;
    localparam int ADDR_W = 4;
    localparam int LINE_W = 10;
    localparam int LMAX   = (1 << LINE_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic std_pal = 1'b0, field_odd = 1'b0, line_start = 1'b0, field_start = 1'b0;
    logic ped_en, ttx_win, vbi_blank;

    always #4 clk = ~clk;

    vbi_line_mask #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .std_pal(std_pal), .field_odd(field_odd), .line_start(line_start),
        .field_start(field_start), .ped_en(ped_en), .ttx_win(ttx_win), .vbi_blank(vbi_blank)
    );

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    logic [7:0] sh [0:8];
    logic [7:0] act [0:8];
    int  mline = 0;
    bit  modd = 0;
    bit  ep = 0, et = 0, eb = 0;

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= 8; i++) begin sh[i] = 8'h00; act[i] = 8'h00; end
            mline = 0; modd = 0; ep = 0; et = 0; eb = 0;
        end else begin
            if (field_start) begin
                mline = 1; modd = field_odd;
                for (int i = 0; i <= 8; i++) act[i] = sh[i];
            end else if (line_start) begin
                if (mline < LMAX) mline++;
            end
            if (field_start || line_start) begin
                int base, first, last;
                logic [15:0] m;
                bit inr, bv;
                base  = (std_pal ? 4 : 0) + (modd ? 0 : 2);
                m     = {act[base+1], act[base]};
                first = std_pal ? 7 : 10;
                last  = first + 15;
                inr   = (mline >= first) && (mline <= last);
                bv    = inr ? m[mline-first] : 1'b0;
                ep    = !std_pal && !bv;
                et    = std_pal && act[8][0] && bv;
                eb    = !act[8][1] && (mline >= 1) && (mline <= last);
            end
            if (wr_en && int'(wr_addr) <= 8) sh[int'(wr_addr)] = wr_data;
        end
    end

    // compare on every clock, away from the edge
    always @(posedge clk) begin
        #2;
        checks++;
        if (ped_en !== ep || ttx_win !== et || vbi_blank !== eb) begin
            errors++;
            $display("FAIL %s line=%0d: ped/ttx/blank actual=%b%b%b expected=%b%b%b",
                     phase, mline, ped_en, ttx_win, vbi_blank, ep, et, eb);
        end
    end

    task automatic tick(input bit ls, input bit fs, input bit fo,
                        input bit we, input int wa, input logic [7:0] wd);
        @(negedge clk);
        line_start = ls; field_start = fs; field_odd = fo;
        wr_en = we; wr_addr = ADDR_W'(wa); wr_data = wd;
    endtask

    task automatic idle(); tick(0, 0, 0, 0, 0, 8'h00); endtask
    task automatic wr(input int a, input logic [7:0] d); tick(0, 0, 0, 1, a, d); endtask
    task automatic lines(input int n);
        for (int i = 0; i < n; i++) begin tick(1, 0, 0, 0, 0, 8'h00); idle(); end
    endtask
    task automatic field(input bit odd, input int n);
        tick(0, 1, odd, 0, 0, 8'h00); idle(); lines(n);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired in phase %s", phase);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        checks++;
        if (ped_en !== 1'b0 || ttx_win !== 1'b0 || vbi_blank !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset flags actual=%b%b%b expected=000", ped_en, ttx_win, vbi_blank);
        end
        @(negedge clk); rst = 1'b0;
        idle(); idle();

        phase = "R10";  // writes before any field start stay invisible
        wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'h0F); wr(3, 8'hF0);
        lines(5);

        phase = "R3";   // NTSC odd mask over lines 1..30
        std_pal = 0;
        field(1, 30);
        phase = "R12";  // even set
        field(0, 30);
        phase = "R4";
        lines(4);

        phase = "R10";  // mid-field write, no effect until next field
        field(1, 8);
        wr(0, 8'hFF); wr(1, 8'hFF);
        lines(20);
        field(1, 26);
        phase = "R10";  // write coinciding with field start
        tick(0, 1, 0, 1, 2, 8'h55); idle(); lines(26);
        field(0, 26);

        phase = "R11";  // std change without strobe holds flags
        std_pal = 1; idle(); idle(); std_pal = 0; idle();

        phase = "R8";   // pass-through set
        wr(8, 8'h02);
        field(1, 28);
        wr(8, 8'h00);

        phase = "R7";   // PAL masks with teletext disabled
        wr(4, 8'hC3); wr(5, 8'h5A); wr(6, 8'h81); wr(7, 8'h7E);
        std_pal = 1;
        field(1, 26);
        phase = "R5";
        wr(8, 8'h01);
        field(1, 26);
        phase = "R6";
        field(0, 26);

        phase = "R9";   // unmapped addresses ignored
        for (int a = 9; a < 16; a++) wr(a, 8'hFF);
        field(1, 26);
        field(0, 26);

        phase = "R2";   // coincident strobes: field start wins
        lines(3);
        tick(1, 1, 1, 0, 0, 8'h00); idle(); lines(24);
        std_pal = 0;
        tick(1, 1, 0, 0, 0, 8'h00); idle(); lines(27);

        phase = "R2";   // saturation, no wrap back into the window
        wr(8, 8'h00);
        field(1, 1040);
        idle(); idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule